// File: doc/BRIEF.md
# BCD Clock-Calendar Counter Chain

This block holds the time of day and the calendar date as packed BCD bytes. It advances by one second on each single-cycle pulse of a 1 Hz tick input. A prescaler outside the block produces that tick. Seconds carry into minutes, minutes into hours, and hours into the day of week and the date. The date carries into the month, and the month into the year. Month lengths are kept, and February of a leap year has a 29th day. A two-bit century field sits in the hours byte, and it flips when the year wraps only if its enable bit is set. A stop bit in the seconds byte freezes the counting.

A host port reads and writes the eight bytes at addresses 0 to 7. Reads are combinational. Writes take effect at the next rising clock edge. While a serial reader is fetching the time, it raises `rd_busy`. During that time the visible bytes stay frozen and incoming ticks are counted as pending. Once the flag drops, the pending ticks are applied one per clock cycle, so no second is lost. A write to the seconds byte discards any pending ticks, so counting restarts on a whole-second boundary.

Top module: `rtc_bcd_calendar`

## Requirements
- R1: After reset, the byte contents at addresses 0..7 are: seconds 0x00, minutes 0x00, hours 0x00, day-of-week 0x01, date 0x01, month 0x01, year 0x00, and control 0x80.
- R2: Each applied tick increments the seconds byte (address 0) in BCD, for example 0x09 becomes 0x10. The value 0x59 wraps to 0x00 and increments the minutes byte (address 1) in BCD.
- R3: When the minutes byte is 0x59 and the hours value in bits 5:0 of address 2 is 0x23, the next applied tick wraps the hours to 0x00. The same tick advances the day-of-week (address 3), which wraps from 7 to 1, and the date (address 4).
- R4: The date wraps to 0x01 and the month (address 5) increments after day 31 of months 01, 03, 05, 07, 08, 10 and 12. The same happens after day 30 of months 04, 06, 09 and 11. Month 0x12 wraps to 0x01 and increments the year (address 6).
- R5: A year whose two-digit value is divisible by 4 is a leap year. In a leap year February ends after 0x29. In any other year it ends after 0x28.
- R6: Bit 7 of the hours byte enables the century bit, and bit 6 is the century bit. When the year wraps from 0x99 to 0x00, bit 6 inverts if bit 7 is 1 and stays unchanged if bit 7 is 0.
- R7: While bit 7 of the seconds byte is 1, ticks change no byte. After it is cleared, the next tick counts again.
- R8: While `rd_busy` is 1, no byte changes on a tick. Up to 2^PEND_W-1 ticks received meanwhile are all applied, one per cycle, after `rd_busy` returns to 0.
- R9: A host write to the seconds byte clears all pending ticks. The written value holds until a new tick arrives.
- R10: The control byte (address 7) stores all 8 written bits and does not change any clock byte. Unused bits read as zero: day-of-week bits 7:3, month bits 7:5, date bits 7:6 and minutes bit 7.
- R11: A host write appears on `host_rdata` for that address right after the clock edge that samples it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_1hz | input | 1 | One-cycle pulse once per second |
| rd_busy | input | 1 | A clock read is in progress; hold visible updates |
| host_wr | input | 1 | Write strobe for the addressed byte |
| host_addr | input | 3 | Byte address 0..7 |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Combinational read data of the addressed byte |

## Verification
A tick sampled at a rising edge, with no read in progress, is visible on `host_rdata` right after that same edge. The bench therefore pulses the tick for one cycle from the falling edge and reads at the next falling edge. A host write is visible after the edge that samples it, so it is read back one falling edge later. Ticks held back by `rd_busy` drain one per cycle after the flag drops. The bench waits several cycles, more than the number pending, before it reads and compares the seconds byte.

// File: rtl/rtc_bcd_pkg.sv
package rtc_bcd_pkg;

    typedef struct packed {
        logic [7:0] ctl;
        logic [7:0] yr;
        logic [7:0] mon;
        logic [7:0] date;
        logic [7:0] dow;
        logic [7:0] hr;
        logic [7:0] min;
        logic [7:0] sec;
    } cal_regs_t;

    function automatic logic [7:0] bcd_step(input logic [7:0] v);
        logic [7:0] r;
        if (v[3:0] == 4'd9) r = {v[7:4] + 4'd1, 4'd0};
        else                r = {v[7:4], v[3:0] + 4'd1};
        return r;
    endfunction

    function automatic logic [7:0] month_last(input logic [7:0] mon, input logic [7:0] yr);
        logic [5:0] s;
        logic       leap;
        logic [7:0] r;
        // ten's digit contributes 10 mod 4 = 2 per unit
        s    = {1'b0, yr[7:4], 1'b0} + {2'b00, yr[3:0]};
        leap = (s[1:0] == 2'b00);
        case (mon)
            8'h02:                      r = leap ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: r = 8'h30;
            default:                    r = 8'h31;
        endcase
        return r;
    endfunction

    function automatic logic [7:0] write_mask(input logic [2:0] a);
        logic [7:0] m;
        case (a)
            3'd1:    m = 8'h7F;
            3'd3:    m = 8'h07;
            3'd4:    m = 8'h3F;
            3'd5:    m = 8'h1F;
            default: m = 8'hFF;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/rtc_tick_guard.sv
module rtc_tick_guard #(
    parameter int PEND_W = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic busy,
    input  logic halt,
    input  logic clear,
    output logic apply
);
    localparam logic [PEND_W-1:0] PEND_MAX = {PEND_W{1'b1}};

    typedef struct packed {
        logic [PEND_W-1:0] pend;
    } guard_t;

    guard_t st_q, st_d;

    always_comb begin
        st_d  = st_q;
        apply = !busy && !halt && !clear && (tick || (st_q.pend != '0));
        if (clear || halt) begin
            st_d.pend = '0;
        end else if (tick && !apply) begin
            if (st_q.pend != PEND_MAX) st_d.pend = st_q.pend + 1'b1;
        end else if (!tick && apply) begin
            st_d.pend = st_q.pend - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    a_r8_pending_saturates: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.pend == PEND_MAX && busy && !clear && !halt) |=> st_q.pend == PEND_MAX);

    a_r9_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> st_q.pend == '0);

endmodule

// File: rtl/rtc_time_chain.sv
module rtc_time_chain
    import rtc_bcd_pkg::*;
(
    input  cal_regs_t cur,
    output cal_regs_t nxt
);
    logic sec_wrap, min_wrap, hr_wrap, date_wrap, mon_wrap, yr_wrap;
    logic [7:0] sec_inc, min_inc, hr_inc, date_inc, mon_inc, yr_inc;

    always_comb begin
        sec_inc  = bcd_step({1'b0, cur.sec[6:0]});
        min_inc  = bcd_step(cur.min);
        hr_inc   = bcd_step({2'b00, cur.hr[5:0]});
        date_inc = bcd_step(cur.date);
        mon_inc  = bcd_step(cur.mon);
        yr_inc   = bcd_step(cur.yr);

        sec_wrap  = (cur.sec[6:0] == 7'h59);
        min_wrap  = sec_wrap && (cur.min == 8'h59);
        hr_wrap   = min_wrap && (cur.hr[5:0] == 6'h23);
        date_wrap = hr_wrap && (cur.date == month_last(cur.mon, cur.yr));
        mon_wrap  = date_wrap && (cur.mon == 8'h12);
        yr_wrap   = mon_wrap && (cur.yr == 8'h99);

        nxt = cur;
        nxt.sec = sec_wrap ? 8'h00 : {cur.sec[7], sec_inc[6:0]};
        if (sec_wrap)
            nxt.min = min_wrap ? 8'h00 : min_inc;
        if (min_wrap)
            nxt.hr[5:0] = hr_wrap ? 6'h00 : hr_inc[5:0];
        if (hr_wrap) begin
            nxt.dow  = (cur.dow[2:0] >= 3'd7) ? 8'h01 : {5'd0, cur.dow[2:0] + 3'd1};
            nxt.date = date_wrap ? 8'h01 : date_inc;
        end
        if (date_wrap)
            nxt.mon = mon_wrap ? 8'h01 : mon_inc;
        if (mon_wrap)
            nxt.yr = yr_wrap ? 8'h00 : yr_inc;
        if (yr_wrap && cur.hr[7])
            nxt.hr[6] = ~cur.hr[6];
    end

endmodule

// File: rtl/rtc_bcd_calendar.sv
module rtc_bcd_calendar
    import rtc_bcd_pkg::*;
#(
    parameter int PEND_W = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_1hz,
    input  logic       rd_busy,
    input  logic       host_wr,
    input  logic [2:0] host_addr,
    input  logic [7:0] host_wdata,
    output logic [7:0] host_rdata
);
    localparam cal_regs_t RST_VAL = '{ctl: 8'h80, yr: 8'h00, mon: 8'h01, date: 8'h01,
                                      dow: 8'h01, hr: 8'h00, min: 8'h00, sec: 8'h00};

    cal_regs_t regs_q, regs_d, adv;
    logic      apply, sec_wr;
    logic [7:0] wval;

    assign sec_wr = host_wr && (host_addr == 3'd0);

    rtc_tick_guard #(.PEND_W(PEND_W)) u_guard (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick_1hz),
        .busy  (rd_busy || host_wr),
        .halt  (regs_q.sec[7]),
        .clear (sec_wr),
        .apply (apply)
    );

    rtc_time_chain u_chain (
        .cur (regs_q),
        .nxt (adv)
    );

    always_comb begin
        regs_d = regs_q;
        wval   = host_wdata & write_mask(host_addr);
        if (apply) regs_d = adv;
        if (host_wr) begin
            case (host_addr)
                3'd0: regs_d.sec  = wval;
                3'd1: regs_d.min  = wval;
                3'd2: regs_d.hr   = wval;
                3'd3: regs_d.dow  = wval;
                3'd4: regs_d.date = wval;
                3'd5: regs_d.mon  = wval;
                3'd6: regs_d.yr   = wval;
                default: regs_d.ctl = wval;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= RST_VAL;
        else        regs_q <= regs_d;
    end

    always_comb begin
        case (host_addr)
            3'd0:    host_rdata = regs_q.sec;
            3'd1:    host_rdata = regs_q.min;
            3'd2:    host_rdata = regs_q.hr;
            3'd3:    host_rdata = regs_q.dow;
            3'd4:    host_rdata = regs_q.date;
            3'd5:    host_rdata = regs_q.mon;
            3'd6:    host_rdata = regs_q.yr;
            default: host_rdata = regs_q.ctl;
        endcase
    end

    a_r8_frozen_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_busy && !host_wr) |=> $stable(regs_q));

    a_r7_frozen_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
        (regs_q.sec[7] && !host_wr) |=> $stable(regs_q));

    a_r2_apply_moves_seconds: assert property (@(posedge clk) disable iff (!rst_n)
        apply |=> regs_q.sec != $past(regs_q.sec));

endmodule

// File: tb/rtc_bcd_calendar_bench.sv
module rtc_bcd_calendar_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_1hz = 1'b0;
    logic       rd_busy = 1'b0;
    logic       host_wr = 1'b0;
    logic [2:0] host_addr = 3'd0;
    logic [7:0] host_wdata = 8'h00;
    logic [7:0] host_rdata;
    int errors = 0;
    int checks = 0;

    always #10 clk = ~clk;

    rtc_bcd_calendar u_rtc_bcd_calendar (
        .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz), .rd_busy(rd_busy),
        .host_wr(host_wr), .host_addr(host_addr), .host_wdata(host_wdata),
        .host_rdata(host_rdata)
    );

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        host_addr = a; host_wdata = d; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic expect_byte(input logic [2:0] a, input logic [7:0] exp, input string req);
        host_addr = a;
        #1;
        checks++;
        if (host_rdata !== exp) begin
            errors++;
            $display("FAIL %s addr %0d: got %02h expected %02h", req, a, host_rdata, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
        tick_1hz = 1'b1;
        @(negedge clk);
        tick_1hz = 1'b0;
    endtask

    task automatic set_clock(input logic [7:0] s, input logic [7:0] m, input logic [7:0] h,
                             input logic [7:0] w, input logic [7:0] dt, input logic [7:0] mo,
                             input logic [7:0] y);
        wr(3'd1, m); wr(3'd2, h); wr(3'd3, w); wr(3'd4, dt);
        wr(3'd5, mo); wr(3'd6, y); wr(3'd0, s);
    endtask

    task automatic t_reset();
        expect_byte(3'd0, 8'h00, "R1"); expect_byte(3'd1, 8'h00, "R1");
        expect_byte(3'd2, 8'h00, "R1"); expect_byte(3'd3, 8'h01, "R1");
        expect_byte(3'd4, 8'h01, "R1"); expect_byte(3'd5, 8'h01, "R1");
        expect_byte(3'd6, 8'h00, "R1"); expect_byte(3'd7, 8'h80, "R1");
    endtask

    task automatic t_seconds();
        wr(3'd0, 8'h09); expect_byte(3'd0, 8'h09, "R11");
        tick(); expect_byte(3'd0, 8'h10, "R2");
        wr(3'd1, 8'h05); wr(3'd0, 8'h59);
        tick(); expect_byte(3'd0, 8'h00, "R2"); expect_byte(3'd1, 8'h06, "R2");
    endtask

    task automatic t_midnight();
        set_clock(8'h59, 8'h59, 8'h23, 8'h07, 8'h10, 8'h03, 8'h21);
        tick();
        expect_byte(3'd2, 8'h00, "R3"); expect_byte(3'd1, 8'h00, "R3");
        expect_byte(3'd3, 8'h01, "R3"); expect_byte(3'd4, 8'h11, "R3");
    endtask

    task automatic t_months();
        set_clock(8'h59, 8'h59, 8'h23, 8'h02, 8'h30, 8'h04, 8'h21);
        tick(); expect_byte(3'd4, 8'h01, "R4"); expect_byte(3'd5, 8'h05, "R4");
        set_clock(8'h59, 8'h59, 8'h23, 8'h02, 8'h31, 8'h01, 8'h21);
        tick(); expect_byte(3'd4, 8'h01, "R4"); expect_byte(3'd5, 8'h02, "R4");
        set_clock(8'h59, 8'h59, 8'h23, 8'h02, 8'h31, 8'h12, 8'h23);
        tick(); expect_byte(3'd5, 8'h01, "R4"); expect_byte(3'd6, 8'h24, "R4");
    endtask

    task automatic t_leap();
        set_clock(8'h59, 8'h59, 8'h23, 8'h02, 8'h28, 8'h02, 8'h24);
        tick(); expect_byte(3'd4, 8'h29, "R5"); expect_byte(3'd5, 8'h02, "R5");
        set_clock(8'h59, 8'h59, 8'h23, 8'h02, 8'h29, 8'h02, 8'h24);
        tick(); expect_byte(3'd4, 8'h01, "R5"); expect_byte(3'd5, 8'h03, "R5");
        set_clock(8'h59, 8'h59, 8'h23, 8'h02, 8'h28, 8'h02, 8'h23);
        tick(); expect_byte(3'd4, 8'h01, "R5"); expect_byte(3'd5, 8'h03, "R5");
    endtask

    task automatic t_century();
        set_clock(8'h59, 8'h59, 8'hE3, 8'h02, 8'h31, 8'h12, 8'h99);
        tick(); expect_byte(3'd2, 8'h80, "R6"); expect_byte(3'd6, 8'h00, "R6");
        set_clock(8'h59, 8'h59, 8'h63, 8'h02, 8'h31, 8'h12, 8'h99);
        tick(); expect_byte(3'd2, 8'h40, "R6"); expect_byte(3'd6, 8'h00, "R6");
    endtask

    task automatic t_stop();
        wr(3'd0, 8'h90);
        tick(); tick(); expect_byte(3'd0, 8'h90, "R7");
        wr(3'd0, 8'h10);
        tick(); expect_byte(3'd0, 8'h11, "R7");
    endtask

    task automatic t_busy();
        wr(3'd0, 8'h20);
        @(negedge clk); rd_busy = 1'b1;
        tick(); tick();
        expect_byte(3'd0, 8'h20, "R8");
        @(negedge clk); rd_busy = 1'b0;
        repeat (4) @(negedge clk);
        expect_byte(3'd0, 8'h22, "R8");
    endtask

    task automatic t_clear();
        wr(3'd0, 8'h40);
        @(negedge clk); rd_busy = 1'b1;
        tick();
        wr(3'd0, 8'h30);
        @(negedge clk); rd_busy = 1'b0;
        repeat (4) @(negedge clk);
        expect_byte(3'd0, 8'h30, "R9");
        tick(); expect_byte(3'd0, 8'h31, "R9");
    endtask

    task automatic t_control();
        set_clock(8'h15, 8'h22, 8'h11, 8'h04, 8'h12, 8'h06, 8'h30);
        wr(3'd7, 8'h5A);
        expect_byte(3'd7, 8'h5A, "R10"); expect_byte(3'd0, 8'h15, "R10");
        expect_byte(3'd1, 8'h22, "R10"); expect_byte(3'd2, 8'h11, "R10");
        wr(3'd3, 8'hFF); expect_byte(3'd3, 8'h07, "R10");
        wr(3'd5, 8'hF2); expect_byte(3'd5, 8'h12, "R10");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_seconds();
        t_midnight();
        t_months();
        t_leap();
        t_century();
        t_stop();
        t_busy();
        t_clear();
        t_control();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule